// File: doc/BRIEF.md
# Multi-Master Hardware Resource Semaphore

This block keeps one ownership claim for each of sixteen shared peripherals (serial ports, converters, timers and similar). Any bus master can claim a resource, release it, and see which master holds it. Each claim or release is a single write that the block checks against the current owner in the same clock edge. Two masters therefore cannot both believe they own the same resource.

Software sees three 32-bit registers with one 2-bit field per resource. Resource i always sits at bits [2i+1:2i].
- The claim register takes a write of a master code into a field.
- The release register takes a write of the holding master's code into a field.
- The status register is read-only and shows the owner code of every field. A code of zero means the resource is free.

Each write comes with the identifier of the master on the bus. A field value is honoured only when it equals that identifier, so a master cannot claim for, or release on behalf of, another master.

Register select encoding on `addr` is as follows. The same select is used for writes and for reads.

| `addr` | Register |
|---|---|
| 0 | claim |
| 1 | release |
| 2 | status |
| 3 | unused |

Top module: `res_semaphore`

## Requirements
- R1: After a synchronous reset every status field is 0 (all resources free), and a status read returns 0x00000000.
- R2: A write to the claim register (addr 0) whose field i holds a non-zero value equal to `master_id` sets status field i to that value at the next clock edge, provided the field was 0.
- R3: A claim write to a field that already holds a non-zero owner code leaves that field unchanged, whatever code is written.
- R4: A write to the release register (addr 1) whose field i equals both `master_id` and the current owner code sets field i to 0. A release carrying any other code leaves the field unchanged.
- R5: A field written with 0, or with a value different from `master_id`, is left unchanged by both claim and release writes. A write with `master_id` equal to 0 changes nothing.
- R6: One write may claim or release several resources at once. Each field is judged on its own under R2 to R5.
- R7: `rd_data` is registered. It shows the register selected by `addr` one clock earlier. Reads of the claim, release and unused registers (addr 0, 1, 3) return 0. A read of the status register (addr 2) returns all owner codes, with field i at bits [2i+1:2i].
- R8: Writes to the status register (addr 2) or to the unused register (addr 3) do not change any owner code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register selected by addr |
| addr | input | 2 | Register select: 0 claim, 1 release, 2 status, 3 unused |
| wr_data | input | 32 | Write data, 2-bit code per resource, field i at [2i+1:2i] |
| master_id | input | 2 | Code of the bus master making the write |
| rd_data | output | 32 | Registered read data of the register selected one cycle earlier |

## Verification
The assertions assume that `addr`, `wr_en`, `wr_data` and `master_id` are stable, known values at each rising edge, and that a single bus port carries at most one write per cycle. The bench respects this by changing every input only on the falling edge and by holding one request for one full cycle. A long deterministic sweep rotates the master code and the target register across many field patterns. A bench model predicts every owner code from the requirements, so claims on free fields, refused steals, mismatched releases and multi-field writes all occur many times.

// File: rtl/res_sem_pkg.sv
package res_sem_pkg;
  typedef enum logic [1:0] {
    SEL_CLAIM   = 2'd0,
    SEL_RELEASE = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_SPARE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/res_sem_slot.sv
module res_sem_slot #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim_en,
  input  logic              rel_en,
  input  logic [CODE_W-1:0] field_val,
  input  logic [CODE_W-1:0] master_id,
  output logic [CODE_W-1:0] owner
);
  logic valid_code;

  // A field counts only when it is non-zero and names the writing master
  assign valid_code = (field_val != '0) && (field_val == master_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= '0;
    end else if (claim_en && valid_code && owner == '0) begin
      owner <= field_val;
    end else if (rel_en && valid_code && owner == field_val) begin
      owner <= '0;
    end
  end

  // R3: a held resource cannot be taken over by a claim
  p_no_steal_r3: assert property (@(posedge clk) disable iff (rst)
    (claim_en && owner != '0) |=> $stable(owner));

  // R4: an owned field is freed only by a matching release
  p_release_match_r4: assert property (@(posedge clk) disable iff (rst)
    (owner != '0 && !(rel_en && field_val == owner)) |=> $stable(owner));

  // R5: a newly recorded owner is always the master that wrote
  p_owner_is_writer_r5: assert property (@(posedge clk) disable iff (rst)
    (owner == '0) |=> (owner == '0 || owner == $past(master_id)));

endmodule

// File: rtl/res_sem_rdport.sv
module res_sem_rdport #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rd_data
);
  import res_sem_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (reg_sel_e'(addr) == SEL_STATUS) begin
      rd_data <= status;
    end else begin
      rd_data <= '0;
    end
  end

  // R7: every register other than status reads as zero
  p_hidden_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_e'(addr) != SEL_STATUS) |=> (rd_data == '0));

endmodule

// File: rtl/res_semaphore.sv
module res_semaphore #(
  parameter int NUM_RES = 16,
  parameter int CODE_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [1:0]                 addr,
  input  logic [NUM_RES*CODE_W-1:0]  wr_data,
  input  logic [CODE_W-1:0]          master_id,
  output logic [NUM_RES*CODE_W-1:0]  rd_data
);
  import res_sem_pkg::*;

  localparam int DATA_W = NUM_RES * CODE_W;

  logic              claim_en;
  logic              rel_en;
  logic [DATA_W-1:0] status;

  assign claim_en = wr_en && (reg_sel_e'(addr) == SEL_CLAIM);
  assign rel_en   = wr_en && (reg_sel_e'(addr) == SEL_RELEASE);

  for (genvar i = 0; i < NUM_RES; i++) begin : g_slot
    res_sem_slot #(.CODE_W(CODE_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .claim_en  (claim_en),
      .rel_en    (rel_en),
      .field_val (wr_data[i*CODE_W +: CODE_W]),
      .master_id (master_id),
      .owner     (status[i*CODE_W +: CODE_W])
    );
  end

  res_sem_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .status  (status),
    .rd_data (rd_data)
  );

  // R8: writes aimed at status or the unused register leave all owners alone
  p_status_ro_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1]) |=> $stable(status));

endmodule

// File: tb/res_semaphore_test.sv
module res_semaphore_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wr_data = '0;
  logic [1:0]  master_id = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model = '0;
  logic [31:0] got;

  res_semaphore uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .master_id(master_id), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench prediction derived from R2..R8
  function automatic logic [31:0] predict(input logic [31:0] st, input logic [1:0] a,
                                          input logic [31:0] d, input logic [1:0] m);
    logic [31:0] r = st;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] f = d[2*i +: 2];
      logic [1:0] o = st[2*i +: 2];
      if (f != 2'd0 && f == m) begin
        if (a == 2'd0 && o == 2'd0) r[2*i +: 2] = f;
        if (a == 2'd1 && o == f)    r[2*i +: 2] = 2'd0;
      end
    end
    return r;
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [31:0] d, input logic [1:0] m);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d; master_id = m;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; master_id = '0;
    model = predict(model, a, d, m);
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model = '0;

    do_read(2'd2, got); check("R1 reset status", got, 32'h0);

    do_write(2'd0, 32'h0000_0080, 2'd2);
    do_read(2'd2, got); check("R2 claim free field", got, 32'h0000_0080);

    do_write(2'd0, 32'h0000_0040, 2'd1);
    do_read(2'd2, got); check("R3 claim on held field", got, 32'h0000_0080);

    do_write(2'd1, 32'h0000_0040, 2'd1);
    do_read(2'd2, got); check("R4 release wrong code", got, 32'h0000_0080);
    do_write(2'd1, 32'h0000_0080, 2'd2);
    do_read(2'd2, got); check("R4 release by owner", got, 32'h0000_0000);

    do_write(2'd0, 32'h0000_0003, 2'd1);
    do_read(2'd2, got); check("R5 code differs from master", got, 32'h0);
    do_write(2'd0, 32'h0000_0000, 2'd0);
    do_read(2'd2, got); check("R5 zero master", got, 32'h0);

    do_write(2'd0, 32'hFFFF_FFFF, 2'd3);
    do_read(2'd2, got); check("R6 claim all", got, 32'hFFFF_FFFF);
    do_write(2'd1, 32'h0000_FFFF, 2'd3);
    do_read(2'd2, got); check("R6 release low half", got, 32'hFFFF_0000);

    do_read(2'd0, got); check("R7 claim reg reads zero", got, 32'h0);
    do_read(2'd1, got); check("R7 release reg reads zero", got, 32'h0);
    do_read(2'd3, got); check("R7 unused reg reads zero", got, 32'h0);

    do_write(2'd2, 32'h5555_5555, 2'd1);
    do_write(2'd3, 32'h5555_5555, 2'd1);
    do_read(2'd2, got); check("R8 status write ignored", got, 32'hFFFF_0000);

    do_write(2'd1, 32'hFFFF_0000, 2'd3);
    do_read(2'd2, got); check("R1 all free again", got, model);

    for (int k = 1; k < 1200; k++) begin
      logic [31:0] d;
      logic [1:0]  m;
      logic [1:0]  a;
      d = (k * 32'h9E37_79B9) ^ (32'(k) << 7) ^ (32'(k) >> 3);
      m = 2'(k) ^ 2'(k >> 2);
      a = (k % 7 == 6) ? 2'(k >> 3) : 2'(k % 2);
      do_write(a, d, m);
      do_read(2'd2, got);
      check("R6 sweep", got, model);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule